// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block sits behind the ingress path of a PCIe root port. It receives inbound memory writes that have already been decoded, and it turns the ones aimed at a programmed capture window into message-signalled interrupts. When a write address equals the 64-bit window base, the write data is taken as a vector number from 0 to 63. The block then sets the matching bit in one of two 32-bit pending banks. Each bank has its own status register, its own mask register and its own level interrupt line.

Next to the vector banks, the block keeps four legacy interrupt pending bits for INTA to INTD. These bits have their own status, mask and interrupt line. Software programs the block through a simple word-addressed register port, with a write strobe and a combinational read. It clears pending bits by writing ones to them.

Top module: `msi_vec_capture`

## Requirements
- R1: After reset, every register reads zero except the capability word, and `irq_lo`, `irq_hi` and `irq_leg` are low.
- R2: The capability word at offset 0 reads 0x00000001, and writes to it have no effect.
- R3: Capture happens only while both control bits are set: bit 0 (capture on) and bit 15 (status on), in the control word at offset 1. The control word keeps and reads back only those two bits.
- R4: A write is captured only when its full 64-bit address equals the base. The base is formed from offset 2 (low word) and offset 3 (high word). A mismatch in either half sets nothing.
- R5: Captured data 0 to 31 sets that bit in the low status word (offset 4). Data 32 to 63 sets bit (data-32) in the high status word (offset 6). The status is visible one clock edge after the write is accepted.
- R6: Captured data of 64 or more sets no status bit in any bank.
- R7: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: A status bit is set whatever its mask bit holds. The masks sit at offsets 5 (low) and 7 (high). `irq_lo` and `irq_hi` are high exactly while their own bank's status AND mask is nonzero.
- R9: If a capture and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A pulse on `leg_set[i]` sets legacy status bit i. Bit 0 is INTA, up to bit 3 for INTD, in the word at offset 8. The legacy mask is at offset 9. Legacy status clears by write-1, and `irq_leg` is high while legacy status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data (vector number) |
| leg_set | input | 4 | Legacy INTA..INTD set pulses |
| irq_lo | output | 1 | Low-bank interrupt |
| irq_hi | output | 1 | High-bank interrupt |
| irq_leg | output | 1 | Legacy interrupt |

## Verification
Every status change lands on the first rising edge after the stimulus, whether it comes from a capture, a legacy pulse or a clear. The interrupt lines are combinational from status and mask, so they follow in that same cycle. A mask write moves an interrupt line right after its own edge. Register reads are combinational and valid as soon as the address settles. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples there or one time unit later. Each result is therefore observed exactly one edge after its cause.

// File: rtl/msi_vec_capture.sv
module msi_vec_capture #(
  parameter int BANK_W = 32,
  parameter int LEG_N  = 4,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          in_wr_valid,
  input  logic [63:0]   in_wr_addr,
  input  logic [31:0]   in_wr_data,
  input  logic [LEG_N-1:0] leg_set,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_leg
);
  localparam int IW    = $clog2(BANK_W);
  localparam int NVEC  = 2 * BANK_W;

  localparam logic [AW-1:0] OFS_CAP     = 0;
  localparam logic [AW-1:0] OFS_CTRL    = 1;
  localparam logic [AW-1:0] OFS_BASE_LO = 2;
  localparam logic [AW-1:0] OFS_BASE_HI = 3;
  localparam logic [AW-1:0] OFS_LO_ST   = 4;
  localparam logic [AW-1:0] OFS_LO_MSK  = 5;
  localparam logic [AW-1:0] OFS_HI_ST   = 6;
  localparam logic [AW-1:0] OFS_HI_MSK  = 7;
  localparam logic [AW-1:0] OFS_LEG_ST  = 8;
  localparam logic [AW-1:0] OFS_LEG_MSK = 9;

  logic              cap_on, stat_on;
  logic [63:0]       base;
  logic [BANK_W-1:0] lo_status, lo_mask, hi_status, hi_mask;
  logic [LEG_N-1:0]  leg_status, leg_mask;

  logic              hit, cap_lo, cap_hi;
  logic [IW-1:0]     cap_idx;
  logic [BANK_W-1:0] lo_set, hi_set, lo_clr, hi_clr;
  logic [LEG_N-1:0]  leg_clr;

  assign hit     = in_wr_valid && cap_on && stat_on && (in_wr_addr == base)
                   && (in_wr_data < NVEC);
  assign cap_idx = in_wr_data[IW-1:0];
  assign cap_hi  = hit && in_wr_data[IW];
  assign cap_lo  = hit && !in_wr_data[IW];
  assign lo_set  = cap_lo ? (BANK_W'(1) << cap_idx) : '0;
  assign hi_set  = cap_hi ? (BANK_W'(1) << cap_idx) : '0;

  assign lo_clr  = (reg_wr && reg_addr == OFS_LO_ST)  ? reg_wdata[BANK_W-1:0] : '0;
  assign hi_clr  = (reg_wr && reg_addr == OFS_HI_ST)  ? reg_wdata[BANK_W-1:0] : '0;
  assign leg_clr = (reg_wr && reg_addr == OFS_LEG_ST) ? reg_wdata[LEG_N-1:0]  : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_on     <= 1'b0;
      stat_on    <= 1'b0;
      base       <= '0;
      lo_mask    <= '0;
      hi_mask    <= '0;
      leg_mask   <= '0;
      lo_status  <= '0;
      hi_status  <= '0;
      leg_status <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFS_CTRL:    begin cap_on <= reg_wdata[0]; stat_on <= reg_wdata[15]; end
          OFS_BASE_LO: base[31:0]  <= reg_wdata;
          OFS_BASE_HI: base[63:32] <= reg_wdata;
          OFS_LO_MSK:  lo_mask  <= reg_wdata[BANK_W-1:0];
          OFS_HI_MSK:  hi_mask  <= reg_wdata[BANK_W-1:0];
          OFS_LEG_MSK: leg_mask <= reg_wdata[LEG_N-1:0];
          default: ;
        endcase
      end
      lo_status  <= (lo_status  & ~lo_clr)  | lo_set;
      hi_status  <= (hi_status  & ~hi_clr)  | hi_set;
      leg_status <= (leg_status & ~leg_clr) | leg_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CAP:     reg_rdata = 32'h1;
      OFS_CTRL:    begin reg_rdata[0] = cap_on; reg_rdata[15] = stat_on; end
      OFS_BASE_LO: reg_rdata = base[31:0];
      OFS_BASE_HI: reg_rdata = base[63:32];
      OFS_LO_ST:   reg_rdata[BANK_W-1:0] = lo_status;
      OFS_LO_MSK:  reg_rdata[BANK_W-1:0] = lo_mask;
      OFS_HI_ST:   reg_rdata[BANK_W-1:0] = hi_status;
      OFS_HI_MSK:  reg_rdata[BANK_W-1:0] = hi_mask;
      OFS_LEG_ST:  reg_rdata[LEG_N-1:0]  = leg_status;
      OFS_LEG_MSK: reg_rdata[LEG_N-1:0]  = leg_mask;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_lo  = |(lo_status & lo_mask);
  assign irq_hi  = |(hi_status & hi_mask);
  assign irq_leg = |(leg_status & leg_mask);

  AST_CAPTURE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> lo_status[$past(cap_idx)]); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hi && hi_clr[cap_idx]) |=> hi_status[$past(cap_idx)]); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_LO_ST && !in_wr_valid)
      |=> ((lo_status & $past(reg_wdata[BANK_W-1:0])) == '0)); // R7

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cap_on && stat_on) && !reg_wr)
      |=> ($stable(lo_status) && $stable(hi_status))); // R3

  AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr_valid && in_wr_data >= NVEC && !reg_wr)
      |=> ($stable(lo_status) && $stable(hi_status))); // R6

  AST_LEG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|leg_set) |=> ((leg_status & $past(leg_set)) == $past(leg_set))); // R10
endmodule

// File: tb/msi_vec_capture_test.sv
module msi_vec_capture_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        in_wr_valid = 0;
  logic [63:0] in_wr_addr = 0;
  logic [31:0] in_wr_data = 0;
  logic [3:0]  leg_set = 0;
  logic        irq_lo, irq_hi, irq_leg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [63:0] BASE = 64'h0000_00AB_1000_0040;

  always #5 clk = ~clk;

  msi_vec_capture uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_wr_valid(in_wr_valid),
    .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data), .leg_set(leg_set),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_leg(irq_leg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic msg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_wr_valid = 1; in_wr_addr = a; in_wr_data = d;
    @(negedge clk);
    in_wr_valid = 0;
  endtask

  task automatic clear_all();
    wr(4, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(8, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 1; i < 10; i++) begin
      rd(i[3:0], v);
      chk("R1 reg zero", v, 0);
    end
    chk("R1 irqs low", {irq_lo, irq_hi, irq_leg}, 0);
  endtask

  task automatic t_cap();
    logic [31:0] v;
    wr(0, 32'h0);
    rd(0, v);
    chk("R2 capability", v, 1);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(2, BASE[31:0]);
    wr(3, BASE[63:32]);
    wr(1, 32'h0000_0001);
    msg(BASE, 3);
    rd(4, v); chk("R3 only bit0", v, 0);
    wr(1, 32'h0000_8000);
    msg(BASE, 3);
    rd(4, v); chk("R3 only bit15", v, 0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R3 ctrl readback", v, 32'h8001);
    msg(BASE, 3);
    rd(4, v); chk("R3 both set", v, 32'h8);
    clear_all();
  endtask

  task automatic t_addr();
    logic [31:0] v;
    msg(BASE ^ 64'h1, 5);
    msg(BASE ^ 64'h1_0000_0000, 5);
    rd(4, v); chk("R4 mismatch", v, 0);
    rd(2, v); chk("R4 base lo", v, BASE[31:0]);
    rd(3, v); chk("R4 base hi", v, BASE[63:32]);
  endtask

  task automatic t_banks();
    logic [31:0] v;
    msg(BASE, 0);
    msg(BASE, 31);
    msg(BASE, 32);
    msg(BASE, 63);
    rd(4, v); chk("R5 low bank", v, 32'h8000_0001);
    rd(6, v); chk("R5 high bank", v, 32'h8000_0001);
    msg(BASE, 64);
    msg(BASE, 32'h8000_0002);
    rd(4, v); chk("R6 low untouched", v, 32'h8000_0001);
    rd(6, v); chk("R6 high untouched", v, 32'h8000_0001);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(4, 32'h0000_0001);
    rd(4, v); chk("R7 partial clear", v, 32'h8000_0000);
    wr(4, 32'h0);
    rd(4, v); chk("R7 zero write", v, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    msg(BASE, 7);
    #1 chk("R8 masked no irq", irq_lo, 0);
    rd(4, v); chk("R8 set while masked", v, 32'h80);
    wr(5, 32'h80);
    #1 chk("R8 irq_lo on", irq_lo, 1);
    chk("R8 irq_hi off", irq_hi, 0);
    msg(BASE, 40);
    wr(7, 32'h100);
    #1 chk("R8 irq_hi on", irq_hi, 1);
    wr(4, 32'h80);
    #1 chk("R8 irq_lo drops", irq_lo, 0);
    chk("R8 irq_hi stays", irq_hi, 1);
    clear_all();
  endtask

  task automatic t_race();
    logic [31:0] v;
    msg(BASE, 36);
    @(negedge clk);
    reg_wr = 1; reg_addr = 6; reg_wdata = 32'h10;
    in_wr_valid = 1; in_wr_addr = BASE; in_wr_data = 36;
    @(negedge clk);
    reg_wr = 0; in_wr_valid = 0;
    rd(6, v); chk("R9 set wins", v, 32'h10);
    clear_all();
  endtask

  task automatic t_leg();
    logic [31:0] v;
    @(negedge clk); leg_set = 4'b0101;
    @(negedge clk); leg_set = 0;
    rd(8, v); chk("R10 leg status", v, 32'h5);
    #1 chk("R10 leg masked", irq_leg, 0);
    wr(9, 32'h4);
    #1 chk("R10 irq_leg on", irq_leg, 1);
    wr(8, 32'h4);
    rd(8, v); chk("R10 leg w1c", v, 32'h1);
    #1 chk("R10 irq_leg off", irq_leg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cap();
    t_ctrl();
    t_addr();
    t_banks();
    t_w1c();
    t_irq();
    t_race();
    t_leg();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule